// File: doc/BRIEF.md
# Lockstep Checkpoint Guard

This block watches two identical execution engines that run the same instruction stream in the same cycles. Each engine presents a result beat every cycle: a valid strobe, a checkpoint flag, a program counter and a result word. When both engines reach a checkpoint with identical beats, the guard commits that program counter and result into its saved checkpoint register and reports the commit. Any disagreement counts as a fault. This covers a differing result, program counter or checkpoint flag, and also a valid strobe raised by only one engine.

The first fault inside a checkpoint interval rolls the engines back. The guard raises a one-cycle retry request carrying the last committed program counter, and the engines restart from there. A second fault before the next clean checkpoint is treated as permanent. The guard fences the unit, stops committing, and holds a sparing request that carries the saved program counter and result, so a spare engine pair can take over the unit's identity and resume at the same instruction. The sparing request is answered in one of two ways: a spare accepts the handoff, or the system reports that no spare exists. In the second case, if the unit holds a critical role, the guard asks for an active unit to be reassigned to that role.

Top module: `lockstep_ckpt_guard`

## Requirements
- R1: After synchronous reset, commit_valid, retry_req, fence, spare_req and reassign_req are 0 and commit_pc equals RESET_PC (default 16'h0100), with commit_data 0.
- R2: In normal running, a cycle where both engines are valid, both checkpoint flags are 1 and program counter and result match gives commit_valid = 1 in the next cycle, with commit_pc and commit_data holding those values.
- R3: Matching valid beats without a checkpoint flag, and cycles with neither engine valid, commit nothing and leave commit_pc and commit_data unchanged.
- R4: The first mismatch in a checkpoint interval gives retry_req = 1 for exactly one cycle, starting in the next cycle, with retry_pc equal to the last committed program counter. No commit occurs. The mismatch may be in the result, the program counter or the checkpoint flag.
- R5: A cycle where exactly one engine raises its valid strobe counts as a mismatch.
- R6: A second mismatch before a clean checkpoint sets fence = 1 and spare_req = 1 in the next cycle, with spare_pc and spare_data equal to the saved checkpoint state.
- R7: A clean checkpoint commit restores the retry allowance, so the next mismatch retries again instead of fencing.
- R8: While fence is 1, no commit occurs, even for agreeing checkpoint beats, and the saved state stays frozen. spare_req holds until spare_ack or spare_none.
- R9: spare_ack drops spare_req in the next cycle, and fence stays at 1 until reset.
- R10: spare_none with role_critical = 1 sets reassign_req in the next cycle and drops spare_req. With role_critical = 0, reassign_req stays 0.
- R11: Beats presented during the cycle in which retry_req is 1 are ignored: an agreeing checkpoint there is not committed.
- R12: Synchronous reset from the fenced condition clears fence and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_a_valid | input | 1 | Engine A beat valid |
| eng_a_ckpt | input | 1 | Engine A checkpoint flag |
| eng_a_pc | input | PW | Engine A program counter |
| eng_a_data | input | DW | Engine A result |
| eng_b_valid | input | 1 | Engine B beat valid |
| eng_b_ckpt | input | 1 | Engine B checkpoint flag |
| eng_b_pc | input | PW | Engine B program counter |
| eng_b_data | input | DW | Engine B result |
| spare_ack | input | 1 | A spare accepted the handoff |
| spare_none | input | 1 | No spare is available |
| role_critical | input | 1 | The unit holds a critical role |
| commit_valid | output | 1 | Checkpoint committed last cycle |
| commit_pc | output | PW | Saved checkpoint program counter |
| commit_data | output | DW | Saved checkpoint result |
| retry_req | output | 1 | Roll back and retry |
| retry_pc | output | PW | Program counter to restart from |
| fence | output | 1 | Unit is fenced |
| spare_req | output | 1 | Sparing request |
| spare_pc | output | PW | Program counter handed to the spare |
| spare_data | output | DW | Result handed to the spare |
| reassign_req | output | 1 | Reassign an active unit to the critical role |

## Verification
Every result of this block is registered once. A commit, a retry pulse, the fence, the sparing request and the reassignment request each appear in the cycle after the beat or acknowledge that caused them. The bench drives each beat on a falling edge and queues the outcome it expects for that cycle. A monitor pops the entry 1 ns after the next rising edge, so the sample falls exactly one register stage later. The retry-window and fenced cases place a beat in the cycle the bench knows the block is not in normal running. Reset state is checked directly at the falling edge that follows the reset edge.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RETRY   = 2'd1,
        ST_FENCED  = 2'd2,
        ST_HANDOFF = 2'd3
    } seq_state_e;

    function automatic logic strobe_skew(input logic va, input logic vb);
        return va ^ vb;
    endfunction

    function automatic logic is_fenced(input seq_state_e s);
        return (s == ST_FENCED) || (s == ST_HANDOFF);
    endfunction

endpackage

// File: rtl/lsc_compare.sv
module lsc_compare #(
    parameter int DW    = 32,
    parameter int PW    = 16,
    parameter int LANES = 4
) (
    input  logic          a_valid,
    input  logic          a_ckpt,
    input  logic [PW-1:0] a_pc,
    input  logic [DW-1:0] a_data,
    input  logic          b_valid,
    input  logic          b_ckpt,
    input  logic [PW-1:0] b_pc,
    input  logic [DW-1:0] b_data,
    output logic          mismatch,
    output logic          clean
);
    import lsc_pkg::*;

    localparam int LW = DW / LANES;

    logic [LANES-1:0] lane_diff;
    logic             ctrl_diff;
    logic             both;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_diff[g] = (a_data[g*LW +: LW] != b_data[g*LW +: LW]);
    end

    always_comb begin
        both      = a_valid & b_valid;
        ctrl_diff = (a_pc != b_pc) | (a_ckpt != b_ckpt);
        mismatch  = strobe_skew(a_valid, b_valid) | (both & (ctrl_diff | (|lane_diff)));
        clean     = both & a_ckpt & ~ctrl_diff & ~(|lane_diff);
    end

endmodule

// File: rtl/lsc_ckpt_store.sv
module lsc_ckpt_store #(
    parameter int          DW       = 32,
    parameter int          PW       = 16,
    parameter logic [PW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_en,
    input  logic [PW-1:0] in_pc,
    input  logic [DW-1:0] in_data,
    output logic [PW-1:0] saved_pc,
    output logic [DW-1:0] saved_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_pc   <= RESET_PC;
            saved_data <= '0;
        end else if (commit_en) begin
            saved_pc   <= in_pc;
            saved_data <= in_data;
        end
    end

    // R3 / R8: saved state only moves on a commit
    a_r3_saved_stable: assert property (@(posedge clk) disable iff (rst)
        !commit_en |=> ($stable(saved_pc) && $stable(saved_data)));

endmodule

// File: rtl/lsc_seq.sv
module lsc_seq #(
    parameter int MAX_RETRY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic mismatch,
    input  logic clean,
    input  logic spare_ack,
    input  logic spare_none,
    input  logic role_critical,
    output logic commit_en,
    output logic commit_valid,
    output logic retry_req,
    output logic fence,
    output logic spare_req,
    output logic reassign_req
);
    import lsc_pkg::*;

    localparam int CW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           reassign_d;

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        reassign_d = reassign_req;
        commit_en  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (mismatch) begin
                    if (cnt_q < CW'(MAX_RETRY)) begin
                        state_d = ST_RETRY;
                        cnt_d   = cnt_q + 1'b1;
                    end else begin
                        state_d = ST_FENCED;
                    end
                end else if (clean) begin
                    commit_en = 1'b1;
                    cnt_d     = '0;
                end
            end
            ST_RETRY:  state_d = ST_RUN;
            ST_FENCED: begin
                if (spare_ack) begin
                    state_d = ST_HANDOFF;
                end else if (spare_none) begin
                    state_d    = ST_HANDOFF;
                    reassign_d = role_critical;
                end
            end
            ST_HANDOFF: state_d = ST_HANDOFF;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_RUN;
            cnt_q        <= '0;
            commit_valid <= 1'b0;
            reassign_req <= 1'b0;
        end else begin
            state_q      <= state_d;
            cnt_q        <= cnt_d;
            commit_valid <= commit_en;
            reassign_req <= reassign_d;
        end
    end

    assign retry_req = (state_q == ST_RETRY);
    assign fence     = is_fenced(state_q);
    assign spare_req = (state_q == ST_FENCED);

    // R4: retry request is a single-cycle pulse
    a_r4_single_retry: assert property (@(posedge clk) disable iff (rst)
        retry_req |=> !retry_req);

    // R8: sparing request held until answered
    a_r8_spare_hold: assert property (@(posedge clk) disable iff (rst)
        (spare_req && !spare_ack && !spare_none) |=> spare_req);

    // R10: reassignment only ever accompanies a fenced unit
    a_r10_reassign_fenced: assert property (@(posedge clk) disable iff (rst)
        reassign_req |-> fence);

endmodule

// File: rtl/lockstep_ckpt_guard.sv
module lockstep_ckpt_guard #(
    parameter int            DW        = 32,
    parameter int            PW        = 16,
    parameter int            LANES     = 4,
    parameter int            MAX_RETRY = 1,
    parameter logic [PW-1:0] RESET_PC  = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eng_a_valid,
    input  logic          eng_a_ckpt,
    input  logic [PW-1:0] eng_a_pc,
    input  logic [DW-1:0] eng_a_data,
    input  logic          eng_b_valid,
    input  logic          eng_b_ckpt,
    input  logic [PW-1:0] eng_b_pc,
    input  logic [DW-1:0] eng_b_data,
    input  logic          spare_ack,
    input  logic          spare_none,
    input  logic          role_critical,
    output logic          commit_valid,
    output logic [PW-1:0] commit_pc,
    output logic [DW-1:0] commit_data,
    output logic          retry_req,
    output logic [PW-1:0] retry_pc,
    output logic          fence,
    output logic          spare_req,
    output logic [PW-1:0] spare_pc,
    output logic [DW-1:0] spare_data,
    output logic          reassign_req
);

    logic          mismatch, clean, commit_en;
    logic [PW-1:0] saved_pc;
    logic [DW-1:0] saved_data;

    lsc_compare #(.DW(DW), .PW(PW), .LANES(LANES)) u_cmp (
        .a_valid (eng_a_valid), .a_ckpt (eng_a_ckpt), .a_pc (eng_a_pc), .a_data (eng_a_data),
        .b_valid (eng_b_valid), .b_ckpt (eng_b_ckpt), .b_pc (eng_b_pc), .b_data (eng_b_data),
        .mismatch(mismatch), .clean(clean)
    );

    lsc_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
        .clk(clk), .rst(rst), .mismatch(mismatch), .clean(clean),
        .spare_ack(spare_ack), .spare_none(spare_none), .role_critical(role_critical),
        .commit_en(commit_en), .commit_valid(commit_valid), .retry_req(retry_req),
        .fence(fence), .spare_req(spare_req), .reassign_req(reassign_req)
    );

    lsc_ckpt_store #(.DW(DW), .PW(PW), .RESET_PC(RESET_PC)) u_store (
        .clk(clk), .rst(rst), .commit_en(commit_en),
        .in_pc(eng_a_pc), .in_data(eng_a_data),
        .saved_pc(saved_pc), .saved_data(saved_data)
    );

    assign commit_pc   = saved_pc;
    assign commit_data = saved_data;
    assign retry_pc    = saved_pc;
    assign spare_pc    = saved_pc;
    assign spare_data  = saved_data;

    // R2: an agreeing checkpoint in normal running commits next cycle
    a_r2_commit: assert property (@(posedge clk) disable iff (rst)
        (!fence && !retry_req && eng_a_valid && eng_b_valid && eng_a_ckpt && eng_b_ckpt
         && eng_a_pc == eng_b_pc && eng_a_data == eng_b_data)
        |=> (commit_valid && commit_pc == $past(eng_a_pc) && commit_data == $past(eng_a_data)));

    // R5: strobe skew in normal running leads to retry or fence
    a_r5_skew: assert property (@(posedge clk) disable iff (rst)
        (!fence && !retry_req && (eng_a_valid != eng_b_valid)) |=> (retry_req || fence));

    // R8: no commit reported while fenced
    a_r8_no_commit_fenced: assert property (@(posedge clk) disable iff (rst)
        fence |-> !commit_valid);

    // R9: fence is sticky until reset
    a_r9_fence_sticky: assert property (@(posedge clk) disable iff (rst)
        fence |=> fence);

endmodule

// File: tb/tb_lockstep_ckpt_guard.sv
module tb_lockstep_ckpt_guard;
    localparam int DW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          av = 0, ac = 0, bv = 0, bc = 0;
    logic [PW-1:0] ap = '0, bp = '0;
    logic [DW-1:0] ad = '0, bd = '0;
    logic          ack = 0, none = 0, crit = 0;
    logic          commit_valid, retry_req, fence, spare_req, reassign_req;
    logic [PW-1:0] commit_pc, retry_pc, spare_pc;
    logic [DW-1:0] commit_data, spare_data;

    always #2 clk = ~clk;

    lockstep_ckpt_guard dut (
        .clk(clk), .rst(rst),
        .eng_a_valid(av), .eng_a_ckpt(ac), .eng_a_pc(ap), .eng_a_data(ad),
        .eng_b_valid(bv), .eng_b_ckpt(bc), .eng_b_pc(bp), .eng_b_data(bd),
        .spare_ack(ack), .spare_none(none), .role_critical(crit),
        .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_data(commit_data),
        .retry_req(retry_req), .retry_pc(retry_pc), .fence(fence),
        .spare_req(spare_req), .spare_pc(spare_pc), .spare_data(spare_data),
        .reassign_req(reassign_req)
    );

    typedef struct {
        logic          cv, rr, fen, sr, ra;
        logic [PW-1:0] pc;
        logic [DW-1:0] dat;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    logic [PW-1:0] spc = 16'h0100;
    logic [DW-1:0] sdat = '0;

    function automatic exp_t mk(logic cv, logic rr, logic fen, logic sr, logic ra, string tag);
        exp_t e;
        e.cv = cv; e.rr = rr; e.fen = fen; e.sr = sr; e.ra = ra;
        e.pc = spc; e.dat = sdat; e.tag = tag;
        return e;
    endfunction

    task automatic beat(input logic a_v, input logic a_c, input logic [PW-1:0] a_p, input logic [DW-1:0] a_d,
                        input logic b_v, input logic b_c, input logic [PW-1:0] b_p, input logic [DW-1:0] b_d,
                        input logic k, input logic n, input logic c, input exp_t e);
        @(negedge clk);
        av = a_v; ac = a_c; ap = a_p; ad = a_d;
        bv = b_v; bc = b_c; bp = b_p; bd = b_d;
        ack = k; none = n; crit = c;
        q.push_back(e);
    endtask

    task automatic agree(input logic c, input logic [PW-1:0] p, input logic [DW-1:0] d, input exp_t e);
        beat(1, c, p, d, 1, c, p, d, 0, 0, 0, e);
    endtask

    task automatic idle(input exp_t e);
        beat(0, 0, '0, '0, 0, 0, '0, '0, 0, 0, 0, e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; av = 0; bv = 0; ac = 0; bc = 0; ack = 0; none = 0; crit = 0;
        @(negedge clk);
        rst = 0;
        spc = 16'h0100; sdat = '0;
        checks++;
        if (commit_valid || retry_req || fence || spare_req || reassign_req
            || commit_pc !== 16'h0100 || commit_data !== '0) begin
            fails++;
            $display("FAIL R1/R12 reset state: got cv%0b rr%0b f%0b sr%0b ra%0b pc=%h d=%h exp all 0 pc=0100 d=0",
                     commit_valid, retry_req, fence, spare_req, reassign_req, commit_pc, commit_data);
        end
    endtask

    // monitor: one register stage after each driven beat
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [PW-1:0] act_rp, exp_rp, act_sp, exp_sp;
                logic [DW-1:0] act_sd, exp_sd;
                e = q.pop_front();
                act_rp = e.rr ? retry_pc : '0;   exp_rp = e.rr ? e.pc : '0;
                act_sp = e.sr ? spare_pc : '0;   exp_sp = e.sr ? e.pc : '0;
                act_sd = e.sr ? spare_data : '0; exp_sd = e.sr ? e.dat : '0;
                checks++;
                if ({commit_valid, retry_req, fence, spare_req, reassign_req} !== {e.cv, e.rr, e.fen, e.sr, e.ra}
                    || commit_pc !== e.pc || commit_data !== e.dat
                    || act_rp !== exp_rp || act_sp !== exp_sp || act_sd !== exp_sd) begin
                    fails++;
                    $display("FAIL %s: got cv%0b rr%0b f%0b sr%0b ra%0b pc=%h d=%h rp=%h sp=%h sd=%h exp cv%0b rr%0b f%0b sr%0b ra%0b pc=%h d=%h rp=%h sp=%h sd=%h",
                             e.tag, commit_valid, retry_req, fence, spare_req, reassign_req, commit_pc, commit_data,
                             act_rp, act_sp, act_sd, e.cv, e.rr, e.fen, e.sr, e.ra, e.pc, e.dat, exp_rp, exp_sp, exp_sd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();                                                      // R1
        agree(0, 16'h0104, 32'h1111_0000, mk(0,0,0,0,0,"R3 no ckpt"));
        idle(mk(0,0,0,0,0,"R3 idle"));
        agree(1, 16'h0104, 32'hAAAA_0001, mk(0,0,0,0,0,"R2 pre"));
        q[q.size()-1].cv = 1; q[q.size()-1].pc = 16'h0104; q[q.size()-1].dat = 32'hAAAA_0001;
        spc = 16'h0104; sdat = 32'hAAAA_0001;
        idle(mk(0,0,0,0,0,"R3 hold after commit"));
        beat(1,0,16'h0108,32'h0000_00FF, 1,0,16'h0108,32'h0000_01FF, 0,0,0, mk(0,1,0,0,0,"R4 data mismatch"));
        agree(1, 16'h0108, 32'hBBBB_0002, mk(0,0,0,0,0,"R11 ignored in retry"));
        agree(1, 16'h0108, 32'hBBBB_0002, mk(0,0,0,0,0,"R7 clean"));
        q[q.size()-1].cv = 1; q[q.size()-1].pc = 16'h0108; q[q.size()-1].dat = 32'hBBBB_0002;
        spc = 16'h0108; sdat = 32'hBBBB_0002;
        beat(1,0,16'h010C,32'h5, 0,0,16'h010C,32'h5, 0,0,0, mk(0,1,0,0,0,"R5 skew R7 retry again"));
        idle(mk(0,0,0,0,0,"R4 pulse ends"));
        agree(0, 16'h0110, 32'h7, mk(0,0,0,0,0,"R7 no clear without ckpt"));
        beat(1,0,16'h0110,32'h9, 1,0,16'h0112,32'h9, 0,0,0, mk(0,0,1,1,0,"R6 pc mismatch fences"));
        agree(1, 16'h0114, 32'hCCCC_0003, mk(0,0,1,1,0,"R8 no commit fenced"));
        idle(mk(0,0,1,1,0,"R8 spare_req held"));
        beat(0,0,'0,'0, 0,0,'0,'0, 1,0,0, mk(0,0,1,0,0,"R9 ack"));
        idle(mk(0,0,1,0,0,"R9 fence sticky"));

        do_reset();                                                      // R12
        agree(1, 16'h0200, 32'hDDDD_0004, mk(0,0,0,0,0,"R2 after reset"));
        q[q.size()-1].cv = 1; q[q.size()-1].pc = 16'h0200; q[q.size()-1].dat = 32'hDDDD_0004;
        spc = 16'h0200; sdat = 32'hDDDD_0004;
        beat(1,1,16'h0204,32'h3, 1,0,16'h0204,32'h3, 0,0,0, mk(0,1,0,0,0,"R4 ckpt flag mismatch"));
        idle(mk(0,0,0,0,0,"R4 idle"));
        beat(1,0,16'h0204,32'h3, 1,0,16'h0204,32'h4, 0,0,0, mk(0,0,1,1,0,"R6 second mismatch"));
        beat(0,0,'0,'0, 0,0,'0,'0, 0,1,1, mk(0,0,1,0,1,"R10 none critical"));
        idle(mk(0,0,1,0,1,"R10 reassign held"));

        do_reset();
        beat(0,0,'0,'0, 1,0,'0,'0, 0,0,0, mk(0,1,0,0,0,"R5 b-only valid"));
        idle(mk(0,0,0,0,0,"R4 idle"));
        beat(1,0,'0,'0, 0,0,'0,'0, 0,0,0, mk(0,0,1,1,0,"R6 skew fences"));
        beat(0,0,'0,'0, 0,0,'0,'0, 0,1,0, mk(0,0,1,0,0,"R10 none not critical"));
        idle(mk(0,0,1,0,0,"R10 no reassign"));
        @(negedge clk);
        av = 0; bv = 0; none = 0;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule